// File: doc/BRIEF.md
# Coherent 64-bit Event Counter Bank

This block holds three 64-bit statistics counters for one channel of a crypto-offload engine. One counts pushes into the descriptor fetch queue. One counts descriptors that complete without error. One counts payload bytes that enter the main execution unit's input queue. The queues and execution units sit outside the block. They appear here as one-cycle strobes and a per-cycle byte count with a traffic-kind code.

Software reaches every counter through a 32-bit register bus. A 64-bit value is read with the low word first. That read places the matching high word in a shared shadow, and the next high-word read returns the shadow. A 64-bit value is written with the high word first. The high word waits in a staging register, and the low-word write loads both halves in one cycle.

When a counter passes all ones it wraps to zero. The wrap marks a sticky status bit, but only if that counter's enable bit is set. The interrupt output is asserted while any status bit and its enable bit are both set.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset, every counter reads zero, the enable and status registers read zero, and `irq` is low.
- R2: The fetch counter (index 0) adds one in each cycle in which `fetchPush` is high.
- R3: The descriptor counter (index 1) adds one in a cycle with `descDone` high and `descErr` low. A cycle with `descDone` and `descErr` both high is not counted.
- R4: In a cycle with `byteValid` high, the byte counter (index 2) adds `byteCount` (0 to 8) when `byteKind` is 0 (main unit), 1 (secondary unit only) or 2 (both units, counted once). It adds nothing when `byteKind` is 3 (context or check-value parcel).
- R5: When a counter wraps from all ones, it lands on the low bits of the sum. The wrap sets status bit i (bit 0 fetch, bit 1 descriptor, bit 2 byte) only if enable bit i is set in that cycle.
- R6: Status bits stay set until software writes 1 to the matching bit of the clear register. If a new wrap and a clear hit the same bit in the same cycle, the bit stays set.
- R7: `irq` is high exactly when some status bit and its enable bit are both set.
- R8: A low-word read returns bits 31:0 of the counter and copies bits 63:32 into the shadow. Every later high-word read returns the shadow, until the next low-word read replaces it, even if the counter changes in between.
- R9: A high-word write changes no counter. The following low-word write loads the counter with {staged high word, written low word}.
- R10: If a low-word commit and an increment hit the same counter in the same cycle, the counter takes the written value and no wrap status is raised.
- R11: Word addresses: 2i is the low word of counter i and 2i+1 its high word (i = 0..2). 6 is the enable register, 7 is the status register (read), and 8 is the clear register (write; reads return 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| fetchPush | input | 1 | One entry pushed into the fetch queue |
| descDone | input | 1 | A descriptor finished |
| descErr | input | 1 | The finishing descriptor halted on error |
| byteValid | input | 1 | Byte count valid this cycle |
| byteKind | input | 2 | Traffic kind of the bytes |
| byteCount | input | 4 | Number of bytes this cycle, 0 to 8 |
| irq | output | 1 | Interrupt request |

## Verification
An event, a commit or a status change shows up right after the clock edge that samples it. A read of the low word, the status register or the enable register is returned in the same cycle, because the read mux is combinational. The high-word read returns the shadow that the low-word read loaded at the edge before. The bench updates its own model at each rising edge and samples read data and `irq` one time unit after the falling edge, so every comparison sees the state that follows the edge just past.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int NUM_CNT = 3;
  localparam int BUS_W   = 32;
  localparam int CNT_W   = 64;
  localparam int HI_W    = CNT_W - BUS_W;
  localparam int AMT_W   = 4;
  localparam int ADDR_W  = 4;

  typedef enum logic [1:0] {
    KIND_PRI  = 2'd0,
    KIND_SEC  = 2'd1,
    KIND_BOTH = 2'd2,
    KIND_CTX  = 2'd3
  } byteKind_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] wrHi;
    logic [NUM_CNT-1:0] wrLo;
    logic [NUM_CNT-1:0] rdLo;
    logic [BUS_W-1:0]   wrData;
  } ctrlStrobe_t;
endpackage

// File: rtl/evt_cnt_dp.sv
module evt_cnt_dp
  import evt_cnt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strb,
  input  logic                            fetchPush,
  input  logic                            descDone,
  input  logic                            descErr,
  input  logic                            byteValid,
  input  byteKind_e                       byteKind,
  input  logic [AMT_W-1:0]                byteCount,
  output logic [NUM_CNT-1:0][BUS_W-1:0]   cntLo,
  output logic [NUM_CNT-1:0]              wrapPulse,
  output logic [HI_W-1:0]                 shadowHi
);
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic [NUM_CNT-1:0][AMT_W-1:0] incAmt;
  logic [HI_W-1:0] stage;
  logic [HI_W-1:0] shadowNext;

  // event qualification per counter
  always_comb begin
    incAmt[0] = AMT_W'(fetchPush);
    incAmt[1] = AMT_W'(descDone && !descErr);
    incAmt[2] = (byteValid && byteKind != KIND_CTX) ? byteCount : '0;
  end

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
      logic [CNT_W:0] sum;
      assign sum          = {1'b0, cnt[g]} + (CNT_W+1)'(incAmt[g]);
      assign wrapPulse[g] = sum[CNT_W] && !strb.wrLo[g];
      assign cntLo[g]     = cnt[g][BUS_W-1:0];

      always_ff @(posedge clk) begin
        if (!rstN)              cnt[g] <= '0;
        else if (strb.wrLo[g])  cnt[g] <= {stage, strb.wrData};
        else                    cnt[g] <= sum[CNT_W-1:0];
      end

      AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrLo[g] |=> cnt[g] == $past({stage, strb.wrData}));  // R10
      AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (!strb.wrLo[g] && cnt[g] == '1 && incAmt[g] == AMT_W'(1)) |=> cnt[g] == '0);  // R5
      AST_HI_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (strb.wrHi[g] && incAmt[g] == '0) |=> $stable(cnt[g]));  // R9
      AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        strb.rdLo[g] |=> shadowHi == $past(cnt[g][CNT_W-1:BUS_W]));  // R8
    end
  endgenerate

  always_comb begin
    shadowNext = shadowHi;
    for (int i = 0; i < NUM_CNT; i++)
      if (strb.rdLo[i]) shadowNext = cnt[i][CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowHi <= '0;
      stage    <= '0;
    end else begin
      shadowHi <= shadowNext;
      if (|strb.wrHi) stage <= strb.wrData;
    end
  end

  AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> byteCount <= AMT_W'(8));  // R4
endmodule

// File: rtl/evt_cnt_ctrl.sv
module evt_cnt_ctrl
  import evt_cnt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic                            regRdEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [BUS_W-1:0]                regWrData,
  input  logic [NUM_CNT-1:0]              wrapPulse,
  input  logic [NUM_CNT-1:0][BUS_W-1:0]   cntLo,
  input  logic [HI_W-1:0]                 shadowHi,
  output ctrlStrobe_t                     strb,
  output logic [BUS_W-1:0]                regRdData,
  output logic                            irq
);
  localparam logic [ADDR_W-1:0] IER_ADDR = ADDR_W'(2*NUM_CNT);
  localparam logic [ADDR_W-1:0] ISR_ADDR = ADDR_W'(2*NUM_CNT + 1);
  localparam logic [ADDR_W-1:0] ICR_ADDR = ADDR_W'(2*NUM_CNT + 2);

  logic [NUM_CNT-1:0] ier, isr, clrMask, setMask;

  always_comb begin
    strb.wrData = regWrData;
    for (int i = 0; i < NUM_CNT; i++) begin
      strb.wrLo[i] = regWrEn && (regAddr == ADDR_W'(2*i));
      strb.wrHi[i] = regWrEn && (regAddr == ADDR_W'(2*i + 1));
      strb.rdLo[i] = regRdEn && (regAddr == ADDR_W'(2*i));
    end
  end

  assign clrMask = (regWrEn && regAddr == ICR_ADDR) ? regWrData[NUM_CNT-1:0] : '0;
  assign setMask = wrapPulse & ier;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ier <= '0;
      isr <= '0;
    end else begin
      isr <= (isr & ~clrMask) | setMask;
      if (regWrEn && regAddr == IER_ADDR) ier <= regWrData[NUM_CNT-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == ADDR_W'(2*i))     regRdData = cntLo[i];
      if (regAddr == ADDR_W'(2*i + 1)) regRdData = shadowHi;
    end
    if (regAddr == IER_ADDR) regRdData = BUS_W'(ier);
    if (regAddr == ISR_ADDR) regRdData = BUS_W'(isr);
  end

  assign irq = |(isr & ier);

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
      AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
        (wrapPulse[g] && ier[g]) |=> isr[g]);  // R5
      AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rstN)
        (!isr[g] && !ier[g]) |=> !isr[g]);  // R5
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (isr[g] && !clrMask[g]) |=> isr[g]);  // R6
    end
  endgenerate
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fetchPush,
  input  logic              descDone,
  input  logic              descErr,
  input  logic              byteValid,
  input  logic [1:0]        byteKind,
  input  logic [3:0]        byteCount,
  output logic              irq
);
  ctrlStrobe_t                   strb;
  logic [NUM_CNT-1:0][BUS_W-1:0] cntLo;
  logic [NUM_CNT-1:0]            wrapPulse;
  logic [HI_W-1:0]               shadowHi;

  evt_cnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .wrapPulse(wrapPulse),
    .cntLo(cntLo), .shadowHi(shadowHi), .strb(strb),
    .regRdData(regRdData), .irq(irq)
  );

  evt_cnt_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchPush(fetchPush),
    .descDone(descDone), .descErr(descErr), .byteValid(byteValid),
    .byteKind(byteKind_e'(byteKind)), .byteCount(byteCount),
    .cntLo(cntLo), .wrapPulse(wrapPulse), .shadowHi(shadowHi)
  );
endmodule

// File: tb/evt_cnt_bank_tb_top.sv
module evt_cnt_bank_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic fetchPush = 1'b0, descDone = 1'b0, descErr = 1'b0, byteValid = 1'b0;
  logic [1:0] byteKind = 2'd0;
  logic [3:0] byteCount = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  evt_cnt_bank dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fetchPush(fetchPush), .descDone(descDone), .descErr(descErr),
    .byteValid(byteValid), .byteKind(byteKind), .byteCount(byteCount),
    .irq(irq)
  );

  // behavioural reference model
  logic [63:0] mCnt [3];
  logic [31:0] mStage, mShadow;
  logic [2:0]  mIer, mIsr, mWrap, mClr;
  logic [63:0] mInc, mNew;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) mCnt[k] = 64'd0;
      mStage = 0; mShadow = 0; mIer = 0; mIsr = 0;
    end else begin
      mWrap = 3'b000;
      for (int k = 0; k < 3; k++)
        if (regRdEn && regAddr == 4'(2*k)) mShadow = mCnt[k][63:32];
      for (int k = 0; k < 3; k++) begin
        case (k)
          0: mInc = fetchPush ? 64'd1 : 64'd0;
          1: mInc = (descDone && !descErr) ? 64'd1 : 64'd0;
          default: mInc = (byteValid && byteKind != 2'd3) ? 64'(byteCount) : 64'd0;
        endcase
        if (regWrEn && regAddr == 4'(2*k)) mCnt[k] = {mStage, regWrData};
        else begin
          mNew = mCnt[k] + mInc;
          if (mNew < mCnt[k]) mWrap[k] = 1'b1;
          mCnt[k] = mNew;
        end
      end
      for (int k = 0; k < 3; k++)
        if (regWrEn && regAddr == 4'(2*k+1)) mStage = regWrData;
      mClr = (regWrEn && regAddr == 4'd8) ? regWrData[2:0] : 3'b000;
      mIsr = (mIsr & ~mClr) | (mWrap & mIer);
      if (regWrEn && regAddr == 4'd6) mIer = regWrData[2:0];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7: irq compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) check("R7 irq", 64'(irq), 64'(|(mIsr & mIer)));
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 check(tag, 64'(regRdData), 64'(exp));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // R8 R11: low word first, then high word from the shadow
  task automatic readCnt(input string tag, input int k);
    logic [31:0] expHi;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 4'(2*k);
    #1 check({tag, " lo"}, 64'(regRdData), 64'(mCnt[k][31:0]));
    expHi = mCnt[k][63:32];
    @(negedge clk);
    regAddr = 4'(2*k+1);
    #1 check({tag, " hi"}, 64'(regRdData), 64'(expHi));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeCnt(input int k, input logic [63:0] v);
    busWrite(4'(2*k+1), v[63:32]);
    busWrite(4'(2*k), v[31:0]);
  endtask

  task automatic pulse(input int n, input bit fp, input bit dd, input bit de,
                       input bit bv, input logic [1:0] bk, input logic [3:0] bc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetchPush = fp; descDone = dd; descErr = de;
      byteValid = bv; byteKind = bk; byteCount = bc;
    end
    @(negedge clk);
    fetchPush = 0; descDone = 0; descErr = 0; byteValid = 0; byteCount = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int k = 0; k < 3; k++) readCnt("R1 reset counter", k);
    readReg("R1 reset enable", 4'd6, 32'd0);
    readReg("R1 reset status", 4'd7, 32'd0);
    check("R1 reset irq", 64'(irq), 64'd0);

    // R2 fetch pushes
    pulse(5, 1, 0, 0, 0, 2'd0, 4'd0);
    readCnt("R2 fetch count", 0);
    check("R2 fetch equals 5", mCnt[0], 64'd5);
    // R3 good and errored descriptors
    pulse(3, 0, 1, 0, 0, 2'd0, 4'd0);
    pulse(2, 0, 1, 1, 0, 2'd0, 4'd0);
    readCnt("R3 desc count", 1);
    check("R3 desc equals 3", mCnt[1], 64'd3);
    // R4 byte kinds
    pulse(1, 0, 0, 0, 1, 2'd0, 4'd8);
    pulse(1, 0, 0, 0, 1, 2'd1, 4'd3);
    pulse(1, 0, 0, 0, 1, 2'd2, 4'd5);
    pulse(1, 0, 0, 0, 1, 2'd3, 4'd7);
    pulse(1, 0, 0, 0, 0, 2'd0, 4'd6);
    readCnt("R4 byte count", 2);
    check("R4 bytes equal 16", mCnt[2], 64'd16);

    // R9 high write alone leaves the counter
    busWrite(4'd1, 32'hFFFF_FFFF);
    readCnt("R9 after hi write", 0);
    busWrite(4'd0, 32'hFFFF_FFFE);
    readCnt("R9 committed", 0);
    // R5 wrap with enable clear: no status
    pulse(2, 1, 0, 0, 0, 2'd0, 4'd0);
    readCnt("R5 wrap to zero", 0);
    readReg("R5 status gated", 4'd7, 32'd0);
    // R5 wrap with enable set
    busWrite(4'd6, 32'h7);
    readReg("R11 enable read", 4'd6, 32'h7);
    writeCnt(1, 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(1, 0, 1, 0, 0, 2'd0, 4'd0);
    readCnt("R5 desc wrapped", 1);
    readReg("R5 desc status", 4'd7, 32'h2);
    check("R7 irq high", 64'(irq), 64'd1);
    writeCnt(2, 64'hFFFF_FFFF_FFFF_FFFC);
    pulse(1, 0, 0, 0, 1, 2'd0, 4'd8);
    readCnt("R5 byte wrap remainder", 2);
    readReg("R5 byte status", 4'd7, 32'h6);
    // R6 clear
    busWrite(4'd8, 32'h2);
    readReg("R6 partial clear", 4'd7, 32'h4);
    readReg("R11 clear reads zero", 4'd8, 32'h0);
    busWrite(4'd8, 32'h4);
    readReg("R6 full clear", 4'd7, 32'h0);
    check("R7 irq low", 64'(irq), 64'd0);
    // R6 set wins over clear
    writeCnt(0, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    regWrEn = 1; regAddr = 4'd8; regWrData = 32'h1; fetchPush = 1;
    @(negedge clk);
    regWrEn = 0; fetchPush = 0;
    readReg("R6 set wins", 4'd7, 32'h1);
    busWrite(4'd8, 32'h1);

    // R10 commit beats increment, no status
    writeCnt(0, 64'hFFFF_FFFF_FFFF_FFFF);
    busWrite(4'd1, 32'h1234_5678);
    @(negedge clk);
    regWrEn = 1; regAddr = 4'd0; regWrData = 32'h9ABC_DEF0; fetchPush = 1;
    @(negedge clk);
    regWrEn = 0; fetchPush = 0;
    readCnt("R10 commit value", 0);
    check("R10 value", mCnt[0], 64'h1234_5678_9ABC_DEF0);
    readReg("R10 no status", 4'd7, 32'h0);

    // R8 shadow keeps the snapshot across a carry into the high word
    writeCnt(0, 64'h0000_0000_FFFF_FFFF);
    readReg("R8 low before carry", 4'd0, 32'hFFFF_FFFF);
    pulse(1, 1, 0, 0, 0, 2'd0, 4'd0);
    readReg("R8 shadow held", 4'd1, 32'h0);
    readCnt("R8 fresh pair", 0);
    // R8 a later low read of another counter refreshes the shadow
    writeCnt(2, 64'h0000_00AB_0000_0001);
    readReg("R8 low of byte", 4'd4, 32'h1);
    readReg("R8 low of fetch", 4'd0, 32'h0);
    readReg("R8 refreshed shadow", 4'd5, 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule